// File: doc/BRIEF.md
# Multidrop UART Character Framer

This block is the serial framing path of a UART channel, covering both directions. The transmitter takes one parallel character together with a character length and an address/data flag. It shifts out a low start bit, the data bits least significant first, one slot bit and one high stop bit. The receiver oversamples the incoming line with a 16x tick. It confirms the start bit half a bit time after the falling edge and then samples every later bit at its centre. For each character it returns the data, the recovered flag and the error indications.

In normal mode the slot bit after the data carries even or odd parity. The transmitter generates it, and the receiver checks it and flags a mismatch. In multidrop mode the same slot carries an address/data flag: 1 marks an address character and 0 marks a data character. In this mode parity is neither generated nor checked. Framing error and break detection work the same in both modes.

Baud rate generation stays outside the block, which sees only a one-cycle oversampling tick enable. Buffering and host registers also stay outside. The configuration inputs are meant to be changed only while both directions are idle.

Top module: `mdrop_framer`

## Requirements
- R1: After reset, txd is high, tx_ready is high and rx_valid is low; whenever tx_ready is high, txd is high.
- R2: A transmitted frame lasts 16 ticks per bit and is, in order: start bit 0, then the low N data bits of tx_data least significant first (N = 5 + cfg_len, so cfg_len 0..3 gives 5..8 bits), then the slot bit, then a stop bit 1. Bits of tx_data at or above position N are not sent.
- R3: In normal mode (cfg_multidrop = 0), the transmitted slot bit makes the count of ones over the N data bits and the slot bit even when cfg_odd = 0 and odd when cfg_odd = 1.
- R4: In multidrop mode (cfg_multidrop = 1), the transmitted slot bit equals tx_flag, whatever the parity of the data.
- R5: Each received character gives exactly one rx_valid pulse lasting one clock. rx_data holds the N received bits in bits N-1..0, with zeros above them.
- R6: In normal mode, rx_perr is 1 exactly when the received slot bit differs from the parity that R3 defines for the received data, and rx_flag is 0.
- R7: In multidrop mode, rx_flag equals the received slot bit and rx_perr is 0.
- R8: rx_ferr is 1 when the stop bit is sampled low. After that the receiver waits for the line to go high before it accepts a new start bit.
- R9: When the line stays low through the whole character, including the stop position, rx_break and rx_ferr are both 1 and rx_data is 0. This holds in both modes. No further character is reported while the line stays low.
- R10: A low pulse on rxd shorter than half a bit time produces no character.
- R11: tx_valid is accepted only while tx_ready is high; tx_ready drops in the cycle after acceptance. A tx_valid during a frame neither alters that frame nor starts another one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Oversampling enable, 16 per bit time |
| cfg_len | input | 2 | Data bits minus 5 (0..3 gives 5..8) |
| cfg_multidrop | input | 1 | 1: slot bit is the address/data flag; 0: slot bit is parity |
| cfg_odd | input | 1 | Normal mode parity sense: 0 even, 1 odd |
| tx_valid | input | 1 | Character offered for transmission |
| tx_data | input | 8 | Character to transmit |
| tx_flag | input | 1 | Address (1) / data (0) flag for multidrop mode |
| tx_ready | output | 1 | Transmitter idle, can accept a character |
| txd | output | 1 | Serial output, idles high |
| rxd | input | 1 | Serial input, asynchronous |
| rx_valid | output | 1 | One-cycle pulse: received character ready |
| rx_data | output | 8 | Received character, zero extended |
| rx_flag | output | 1 | Received address/data flag (multidrop mode) |
| rx_perr | output | 1 | Parity error (normal mode only) |
| rx_ferr | output | 1 | Stop bit sampled low |
| rx_break | output | 1 | Whole character, including the stop bit, was low |

## Verification
Random characters cover all four lengths, both modes, both parity senses and both flag values. They are sent through the transmitter, and the line is sampled at bit centres and compared bit by bit against a frame built in the bench. The same line is looped into the receiver, so each character also checks receive alignment and flag recovery. Directed receive frames isolate single faults: a flipped slot bit tells a parity check apart from a flag pass-through, and a low stop bit with nonzero data tells framing error apart from break. A line held low tells break apart from framing error and shows the receiver waiting for the line to go high. A short glitch shows the start bit is confirmed before a character begins. A tx_valid pulse during a frame shows that the transmitter ignores input while busy.

// File: rtl/mdf_pkg.sv
package mdf_pkg;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_SLOT, RX_STOP, RX_HOLD
  } rx_state_e;

  // number of data bits for a length code
  function automatic logic [3:0] char_bits(input logic [1:0] len);
    return 4'd5 + {2'b00, len};
  endfunction

  // clear bits above the character length
  function automatic logic [7:0] keep_bits(input logic [7:0] d, input logic [1:0] len);
    case (len)
      2'd0:    return d & 8'h1F;
      2'd1:    return d & 8'h3F;
      2'd2:    return d & 8'h7F;
      default: return d;
    endcase
  endfunction

  // slot bit: flag in multidrop mode, parity otherwise
  function automatic logic slot_bit(input logic [7:0] d, input logic [1:0] len,
                                    input logic md, input logic odd, input logic flag);
    return md ? flag : ((^keep_bits(d, len)) ^ odd);
  endfunction

  // full frame, first bit on the line in bit 0, unused upper bits high
  function automatic logic [10:0] build_frame(input logic [7:0] d, input logic [1:0] len,
                                              input logic md, input logic odd,
                                              input logic flag);
    logic [10:0] f;
    int n;
    n = int'(char_bits(len));
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i < n) f[i+1] = d[i];
    end
    f[n+1] = slot_bit(d, len, md, odd, flag);
    return f;
  endfunction

  // received bits arrive at the top of the shift register; move them down
  function automatic logic [7:0] align_char(input logic [7:0] s, input logic [1:0] len);
    case (len)
      2'd0:    return {3'b000, s[7:3]};
      2'd1:    return {2'b00, s[7:2]};
      2'd2:    return {1'b0, s[7:1]};
      default: return s;
    endcase
  endfunction

endpackage

// File: rtl/mdf_sync.sv
module mdf_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= RESET_VAL;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RESET_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mdf_tx.sv
module mdf_tx
  import mdf_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       start,
  input  logic [7:0] data,
  input  logic [1:0] len,
  input  logic       md,
  input  logic       odd,
  input  logic       flag,
  output logic       busy,
  output logic       txd,
  output logic       bit_evt
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] TLAST = CW'(OSR - 1);

  logic [CW-1:0] tcnt;
  logic [3:0]    bits_left;
  logic [9:0]    pending;
  logic [10:0]   frame;

  assign frame   = build_frame(data, len, md, odd, flag);
  assign bit_evt = busy && tick && (tcnt == TLAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      txd       <= 1'b1;
      tcnt      <= '0;
      bits_left <= '0;
      pending   <= '1;
    end else if (!busy) begin
      if (start) begin
        busy      <= 1'b1;
        txd       <= frame[0];
        pending   <= frame[10:1];
        bits_left <= char_bits(len) + 4'd2;
        tcnt      <= '0;
      end
    end else if (tick) begin
      if (tcnt == TLAST) begin
        tcnt <= '0;
        if (bits_left == 4'd0) begin
          busy <= 1'b0;
          txd  <= 1'b1;
        end else begin
          txd       <= pending[0];
          pending   <= {1'b1, pending[9:1]};
          bits_left <= bits_left - 4'd1;
        end
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdf_rx.sv
module mdf_rx
  import mdf_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       line,
  input  logic [1:0] len,
  input  logic       md,
  input  logic       odd,
  output logic       valid,
  output logic [7:0] data,
  output logic       flag,
  output logic       perr,
  output logic       ferr,
  output logic       brk,
  output logic       samp_evt,
  output logic       frame_evt
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] TLAST = CW'(OSR - 1);
  localparam logic [CW-1:0] HLAST = CW'(OSR / 2 - 1);

  rx_state_e     st;
  logic [CW-1:0] tcnt;
  logic [3:0]    bidx;
  logic [7:0]    sreg;
  logic          slot_q;
  logic          all_low;
  logic [7:0]    got;

  assign got       = align_char(sreg, len);
  assign samp_evt  = tick && (tcnt == TLAST) &&
                     (st == RX_DATA || st == RX_SLOT || st == RX_STOP);
  assign frame_evt = samp_evt && (st == RX_STOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= RX_IDLE;
      tcnt    <= '0;
      bidx    <= '0;
      sreg    <= '0;
      slot_q  <= 1'b0;
      all_low <= 1'b0;
      valid   <= 1'b0;
      data    <= '0;
      flag    <= 1'b0;
      perr    <= 1'b0;
      ferr    <= 1'b0;
      brk     <= 1'b0;
    end else begin
      valid <= 1'b0;
      case (st)
        RX_IDLE: begin
          if (tick && !line) begin
            st   <= RX_START;
            tcnt <= '0;
          end
        end
        RX_START: begin
          if (tick) begin
            if (tcnt == HLAST) begin
              tcnt <= '0;
              if (!line) begin
                st      <= RX_DATA;
                bidx    <= '0;
                all_low <= 1'b1;
              end else begin
                st <= RX_IDLE;
              end
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        RX_DATA, RX_SLOT, RX_STOP: begin
          if (tick) begin
            if (tcnt != TLAST) tcnt <= tcnt + 1'b1;
            else               tcnt <= '0;
          end
          if (samp_evt) begin
            all_low <= all_low & ~line;
            if (st == RX_DATA) begin
              sreg <= {line, sreg[7:1]};
              if (bidx == char_bits(len) - 4'd1) st <= RX_SLOT;
              else                               bidx <= bidx + 4'd1;
            end else if (st == RX_SLOT) begin
              slot_q <= line;
              st     <= RX_STOP;
            end else begin
              valid <= 1'b1;
              data  <= got;
              flag  <= md & slot_q;
              perr  <= !md && (slot_q != slot_bit(got, len, 1'b0, odd, 1'b0));
              ferr  <= !line;
              brk   <= all_low & ~line;
              st    <= line ? RX_IDLE : RX_HOLD;
            end
          end
        end
        RX_HOLD: begin
          if (line) st <= RX_IDLE;
        end
        default: st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mdrop_framer.sv
module mdrop_framer #(
  parameter int OSR       = 16,
  parameter int SYNC_FLOP = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic [1:0] cfg_len,
  input  logic       cfg_multidrop,
  input  logic       cfg_odd,
  input  logic       tx_valid,
  input  logic [7:0] tx_data,
  input  logic       tx_flag,
  output logic       tx_ready,
  output logic       txd,
  input  logic       rxd,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       rx_flag,
  output logic       rx_perr,
  output logic       rx_ferr,
  output logic       rx_break
);
  logic tx_busy;
  logic tx_accept;
  logic tx_bit_evt;
  logic rx_line;
  logic rx_samp_evt;
  logic rx_frame_evt;

  assign tx_ready  = ~tx_busy;
  assign tx_accept = tx_valid & tx_ready;

  mdf_tx #(.OSR(OSR)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick16),
    .start   (tx_accept),
    .data    (tx_data),
    .len     (cfg_len),
    .md      (cfg_multidrop),
    .odd     (cfg_odd),
    .flag    (tx_flag),
    .busy    (tx_busy),
    .txd     (txd),
    .bit_evt (tx_bit_evt)
  );

  mdf_sync #(.STAGES(SYNC_FLOP), .RESET_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (rxd),
    .q     (rx_line)
  );

  mdf_rx #(.OSR(OSR)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick16),
    .line      (rx_line),
    .len       (cfg_len),
    .md        (cfg_multidrop),
    .odd       (cfg_odd),
    .valid     (rx_valid),
    .data      (rx_data),
    .flag      (rx_flag),
    .perr      (rx_perr),
    .ferr      (rx_ferr),
    .brk       (rx_break),
    .samp_evt  (rx_samp_evt),
    .frame_evt (rx_frame_evt)
  );
endmodule

// File: rtl/mdf_chk.sv
module mdf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cfg_len,
  input logic       cfg_multidrop,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       txd,
  input logic       rx_valid,
  input logic [7:0] rx_data,
  input logic       rx_flag,
  input logic       rx_perr,
  input logic       rx_ferr,
  input logic       rx_break,
  input logic       tx_bit_evt,
  input logic       rx_frame_evt
);
  // R1
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> txd);

  // R11
  tx_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  // R11
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_ready && !tx_bit_evt) |=> $stable(txd));

  // R5
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R5
  rx_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_frame_evt |=> rx_valid);

  // R5
  rx_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && cfg_len == 2'd0) |-> (rx_data[7:5] == 3'd0));

  // R6
  normal_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !cfg_multidrop) |-> !rx_flag);

  // R7
  md_perr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && cfg_multidrop) |-> !rx_perr);

  // R9
  brk_ferr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_break) |-> (rx_ferr && rx_data == 8'd0));
endmodule

bind mdrop_framer mdf_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_len       (cfg_len),
  .cfg_multidrop (cfg_multidrop),
  .tx_valid      (tx_valid),
  .tx_ready      (tx_ready),
  .txd           (txd),
  .rx_valid      (rx_valid),
  .rx_data       (rx_data),
  .rx_flag       (rx_flag),
  .rx_perr       (rx_perr),
  .rx_ferr       (rx_ferr),
  .rx_break      (rx_break),
  .tx_bit_evt    (tx_bit_evt),
  .rx_frame_evt  (rx_frame_evt)
);

// File: tb/tb_mdrop_framer.sv
module tb_mdrop_framer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic [1:0] cfg_len = 2'd3;
  logic       cfg_multidrop = 1'b0;
  logic       cfg_odd = 1'b0;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = 8'd0;
  logic       tx_flag = 1'b0;
  logic       tx_ready, txd;
  logic       rxd;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       rx_flag, rx_perr, rx_ferr, rx_break;

  logic loop_en = 1'b0;
  logic drv = 1'b1;
  assign rxd = loop_en ? txd : drv;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  int         cap_cnt = 0;
  logic [7:0] cap_data;
  logic       cap_flag, cap_perr, cap_ferr, cap_brk;

  mdrop_framer dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16),
    .cfg_len(cfg_len), .cfg_multidrop(cfg_multidrop), .cfg_odd(cfg_odd),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_flag(tx_flag),
    .tx_ready(tx_ready), .txd(txd), .rxd(rxd),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_flag(rx_flag),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_break(rx_break)
  );

  always #10 clk = ~clk;

  // one oversampling tick every second clock: a bit lasts 32 clocks
  always @(negedge clk) tick16 <= rst_n ? ~tick16 : 1'b0;

  always @(negedge clk) begin
    if (rx_valid) begin
      cap_cnt  <= cap_cnt + 1;
      cap_data <= rx_data;
      cap_flag <= rx_flag;
      cap_perr <= rx_perr;
      cap_ferr <= rx_ferr;
      cap_brk  <= rx_break;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      tests = tests + 1;
      $display("FAIL watchdog: got %0d cycles, expected under 150000", cycles);
      finish_run();
    end
  end

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // ---- reference model, written from the requirements ----
  function automatic int nbits(input logic [1:0] len);
    return 5 + int'(len);
  endfunction

  function automatic logic [7:0] trim(input logic [7:0] d, input logic [1:0] len);
    return d & 8'((1 << nbits(len)) - 1);
  endfunction

  function automatic logic ref_slot(input logic [7:0] d, input logic [1:0] len,
                                    input logic md, input logic odd, input logic flag);
    int ones;
    if (md) return flag;
    ones = $countones(trim(d, len));
    return ((ones % 2) == 1) ^ odd;
  endfunction

  // bits in line order, bit 0 first; zeros above the stop bit
  function automatic logic [10:0] ref_frame(input logic [7:0] d, input logic [1:0] len,
                                            input logic md, input logic odd, input logic flag);
    int n;
    n = nbits(len);
    return (11'd1 << (n + 2)) | (11'(ref_slot(d, len, md, odd, flag)) << (n + 1)) |
           (11'(trim(d, len)) << 1);
  endfunction

  task automatic set_cfg(input logic [1:0] len, input logic md, input logic odd);
    cfg_len = len;
    cfg_multidrop = md;
    cfg_odd = odd;
  endtask

  // transmit one character and check the line and the looped-back receiver
  task automatic tx_case(input logic [7:0] d, input logic [1:0] len, input logic md,
                         input logic odd, input logic flag, input bit poke);
    logic [10:0] got, exp;
    int n, c0, w;
    n = nbits(len);
    exp = ref_frame(d, len, md, odd, flag);
    got = '0;
    loop_en = 1'b1;
    while (!tx_ready) @(negedge clk);
    set_cfg(len, md, odd);
    c0 = cap_cnt;
    tx_data = d; tx_flag = flag; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    // R11: tx_ready falls once the character is taken
    check(tx_ready == 1'b0, "R11 ready after accept", int'(tx_ready), 0);
    w = 0;
    while (txd && w < 100) begin @(negedge clk); w++; end
    repeat (16) @(negedge clk);
    got[0] = txd;
    for (int k = 1; k < n + 3; k++) begin
      if (k == 1 && poke) begin
        tx_data = ~d; tx_flag = ~flag; tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        repeat (31) @(negedge clk);
      end else begin
        repeat (32) @(negedge clk);
      end
      got[k] = txd;
    end
    // R2 R3 R4: frame bits at their centres
    check(got == exp, md ? "R2/R4 tx frame" : "R2/R3 tx frame", int'(got), int'(exp));
    repeat (40) @(negedge clk);
    // R5 R6 R7: loopback reception
    check(cap_cnt == c0 + 1, "R5 one char received", cap_cnt - c0, 1);
    check(cap_data == trim(d, len), "R5 rx data", int'(cap_data), int'(trim(d, len)));
    check(cap_flag == (md & flag), md ? "R7 rx flag" : "R6 rx flag zero",
          int'(cap_flag), int'(md & flag));
    check(cap_perr == 1'b0 && cap_ferr == 1'b0 && cap_brk == 1'b0, "R6 clean char flags",
          int'({cap_perr, cap_ferr, cap_brk}), 0);
    if (poke) begin
      // R11: nothing follows the frame after a tx_valid pulse while busy
      logic low_seen;
      low_seen = 1'b0;
      repeat (96) begin @(negedge clk); if (!txd) low_seen = 1'b1; end
      check(!low_seen && tx_ready, "R11 busy tx_valid ignored", int'(low_seen), 0);
    end
    loop_en = 1'b0;
  endtask

  task automatic drive_bits(input logic [10:0] bits, input int n);
    for (int i = 0; i < n; i++) begin
      drv = bits[i];
      repeat (32) @(negedge clk);
    end
    drv = 1'b1;
    repeat (48) @(negedge clk);
  endtask

  initial begin
    logic [10:0] fr;
    int c0, n;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(txd == 1'b1 && tx_ready == 1'b1 && rx_valid == 1'b0, "R1 reset outputs",
          int'({txd, tx_ready, rx_valid}), 3'b110);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // directed transmit corners
    tx_case(8'hE5, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);  // upper bits dropped, even parity
    tx_case(8'h80, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0);  // odd parity, flag ignored
    tx_case(8'h00, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0);  // address flag on zero data
    tx_case(8'hFF, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1);  // data flag, tx_valid while busy

    // constrained random loopback
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 30; i++) begin
      tx_case(8'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'b0);
    end

    // R6: wrong parity in normal mode
    set_cfg(2'd3, 1'b0, 1'b0);
    fr = ref_frame(8'h35, 2'd3, 1'b0, 1'b0, 1'b0) ^ (11'd1 << 9);
    c0 = cap_cnt;
    drive_bits(fr, 11);
    check(cap_cnt == c0 + 1 && cap_perr == 1'b1, "R6 parity error flagged",
          int'(cap_perr), 1);

    // R7: multidrop with the slot bit set, parity not checked
    set_cfg(2'd1, 1'b1, 1'b0);
    fr = ref_frame(8'h2A, 2'd1, 1'b1, 1'b0, 1'b1);
    c0 = cap_cnt;
    drive_bits(fr, 9);
    check(cap_cnt == c0 + 1 && cap_flag == 1'b1 && cap_perr == 1'b0 && cap_data == 8'h2A,
          "R7 address char", int'({cap_flag, cap_perr, cap_data}), int'({2'b10, 8'h2A}));

    // R8: stop bit low with nonzero data
    set_cfg(2'd2, 1'b1, 1'b0);
    fr = ref_frame(8'h41, 2'd2, 1'b1, 1'b0, 1'b0) & ~(11'd1 << 9);
    c0 = cap_cnt;
    drive_bits(fr, 10);
    check(cap_cnt == c0 + 1 && cap_ferr == 1'b1 && cap_brk == 1'b0, "R8 framing error",
          int'({cap_ferr, cap_brk}), 2'b10);
    fr = ref_frame(8'h1C, 2'd2, 1'b1, 1'b0, 1'b0);
    drive_bits(fr, 10);
    check(cap_cnt == c0 + 2 && cap_ferr == 1'b0 && cap_data == 8'h1C, "R8 recovery",
          int'(cap_data), 8'h1C);

    // R9: break in both modes
    for (int m = 0; m < 2; m++) begin
      set_cfg(2'd3, 1'(m), 1'b1);
      n = 11;
      c0 = cap_cnt;
      drv = 1'b0;
      repeat (n * 32 + 200) @(negedge clk);
      check(cap_cnt == c0 + 1 && cap_brk == 1'b1 && cap_ferr == 1'b1 && cap_data == 8'd0,
            "R9 break reported", int'({cap_brk, cap_ferr, cap_data}), int'({2'b11, 8'd0}));
      drv = 1'b1;
      repeat (100) @(negedge clk);
      check(cap_cnt == c0 + 1, "R9 no char while low", cap_cnt - c0, 1);
      fr = ref_frame(8'h5A, 2'd3, 1'(m), 1'b1, 1'b0);
      drive_bits(fr, 11);
      check(cap_cnt == c0 + 2 && cap_data == 8'h5A && cap_brk == 1'b0, "R9 after break",
            int'(cap_data), 8'h5A);
    end

    // R10: short glitch
    c0 = cap_cnt;
    drv = 1'b0;
    repeat (8) @(negedge clk);
    drv = 1'b1;
    repeat (500) @(negedge clk);
    check(cap_cnt == c0, "R10 glitch ignored", cap_cnt - c0, 0);

    finish_run();
  end
endmodule